// File: doc/BRIEF.md
# Line-Region Sequence Selector

This block divides one field of sensor readout into up to four vertical regions and, for each region, picks which of four individual timing sequences drives a signal. A shared line counter is cleared by the field-start strobe and advanced by the line strobe. Three independent selector lanes compare the line count against their own boundary lines. They serve the clamp, pixel-blanking and horizontal-blanking signals. Each lane emits a registered 2-bit sequence select.

Region 0 always begins at line 0. Three programmable boundary lines per signal open regions 1, 2 and 3. A boundary counts only while the chain of boundaries is strictly rising and non-zero. Each lane's pointer word maps every region to a sequence number. The waveforms of the sequences are generated elsewhere.

Top module: `line_region_seqsel`

## Requirements
- R1: A field-start pulse clears the line count to 0. On the same clock edge, each select output takes the region-0 field of its pointer word, which is bits [1:0].
- R2: Each line-strobe pulse, when no field-start pulse is present, raises the line count by one.
- R3: A lane's region 1 begins at the line equal to its first boundary. The first boundary is bits [LINE_W-1:0] of the boundary input. The pointer field for region k is bits [2k+1:2k] of the pointer input.
- R4: Region 2 begins at the second boundary, bits [2*LINE_W-1:LINE_W]. Region 3 begins at the third boundary, bits [3*LINE_W-1:2*LINE_W].
- R5: A first boundary of 0 disables all three boundaries, so the lane stays in region 0 for the whole field.
- R6: A boundary that is not greater than the boundary before it disables itself and every later boundary.
- R7: The clamp, pixel-blanking and horizontal-blanking lanes use only their own boundaries and pointers.
- R8: A select output changes only on the clock edge that samples a line strobe or a field-start pulse. It then shows the pointer field for the region of the line just entered. Pointer or boundary changes between strobes have no effect on the outputs until the next strobe.
- R9: When the field-start pulse and the line strobe are high in the same cycle, the field start wins and the line count becomes 0.
- R10: The line count saturates at 2^LINE_W-1 and does not wrap.
- R11: While reset is asserted, the line count is 0 and all select outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_start_i | input | 1 | Field-start (VD) strobe, one cycle |
| line_stb_i | input | 1 | Line strobe, one cycle per line |
| clamp_bnd_i | input | 3*LINE_W | Clamp boundaries 1..3 |
| clamp_ptr_i | input | 8 | Clamp region-to-sequence map |
| pblk_bnd_i | input | 3*LINE_W | Pixel-blanking boundaries 1..3 |
| pblk_ptr_i | input | 8 | Pixel-blanking region-to-sequence map |
| hblk_bnd_i | input | 3*LINE_W | Horizontal-blanking boundaries 1..3 |
| hblk_ptr_i | input | 8 | Horizontal-blanking region-to-sequence map |
| clamp_sel_o | output | 2 | Clamp sequence select |
| pblk_sel_o | output | 2 | Pixel-blanking sequence select |
| hblk_sel_o | output | 2 | Horizontal-blanking sequence select |

## Verification
Every select result is due on the first rising edge that samples the strobe. The line count is next-state decoded, so no extra line of delay occurs. The bench raises strobes at a falling edge and drops them at the next falling edge. It then compares outputs at that falling edge, half a period after the update. Multi-line steps hold the line strobe high for N edges, and the check follows the last of them. For the no-effect cases, inputs change with no strobe and the outputs are read several cycles later, before the next strobe.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  localparam int NUM_BOUNDS  = 3;
  localparam int NUM_REGIONS = NUM_BOUNDS + 1;
  localparam int SEL_W       = 2;
  localparam int PTR_W       = NUM_REGIONS * SEL_W;
  localparam int NUM_LANES   = 3;
  localparam int REG_W       = $clog2(NUM_REGIONS);
  typedef logic [SEL_W-1:0] seq_sel_t;
endpackage

// File: rtl/lrs_line_counter.sv
module lrs_line_counter #(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_start_i,
  input  logic              line_stb_i,
  output logic [LINE_W-1:0] line_next_o,
  output logic              boundary_o
);
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  logic [LINE_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  assign cnt_en = field_start_i | line_stb_i;

  always_comb begin
    cnt_d = cnt_q;
    if (field_start_i) begin
      cnt_d = '0;
    end else if (line_stb_i && (cnt_q != LINE_MAX)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign line_next_o = cnt_d;
  assign boundary_o  = cnt_en;

  // R1
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_start_i |=> (cnt_q == '0));
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb_i && !field_start_i && (cnt_q != LINE_MAX)) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R10
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb_i && !field_start_i && (cnt_q == LINE_MAX)) |=> (cnt_q == LINE_MAX));
endmodule

// File: rtl/lrs_region_decode.sv
module lrs_region_decode
  import lrs_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic [LINE_W-1:0]            line_i,
  input  logic [NUM_BOUNDS*LINE_W-1:0] bnd_i,
  output logic [REG_W-1:0]             region_o
);
  logic [NUM_BOUNDS-1:0] valid;
  logic [NUM_BOUNDS-1:0] hit;

  for (genvar k = 0; k < NUM_BOUNDS; k++) begin : g_bnd
    logic [LINE_W-1:0] pos;
    assign pos = bnd_i[k*LINE_W +: LINE_W];
    if (k == 0) begin : g_first
      assign valid[k] = (pos != '0);
    end else begin : g_rest
      assign valid[k] = valid[k-1] && (pos > bnd_i[(k-1)*LINE_W +: LINE_W]);
    end
    assign hit[k] = valid[k] && (line_i >= pos);
  end

  always_comb begin
    region_o = '0;
    for (int k = 0; k < NUM_BOUNDS; k++) begin
      if (hit[k]) region_o = REG_W'(k + 1);
    end
  end
endmodule

// File: rtl/lrs_region_sel.sv
module lrs_region_sel
  import lrs_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         boundary_i,
  input  logic [LINE_W-1:0]            line_next_i,
  input  logic [NUM_BOUNDS*LINE_W-1:0] bnd_i,
  input  logic [PTR_W-1:0]             ptr_i,
  output seq_sel_t                     sel_o
);
  logic [REG_W-1:0] region;
  seq_sel_t         sel_q, sel_d;

  lrs_region_decode #(.LINE_W(LINE_W)) u_decode (
    .line_i   (line_next_i),
    .bnd_i    (bnd_i),
    .region_o (region)
  );

  always_comb begin
    sel_d = sel_q;
    if (boundary_i) sel_d = ptr_i[region*SEL_W +: SEL_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else begin
      sel_q <= sel_d;
    end
  end

  assign sel_o = sel_q;

  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_i |=> $stable(sel_q));
  // R1
  sel_region0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && (line_next_i == '0)) |=> (sel_q == $past(ptr_i[SEL_W-1:0])));
endmodule

// File: rtl/line_region_seqsel.sv
module line_region_seqsel
  import lrs_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         field_start_i,
  input  logic                         line_stb_i,
  input  logic [NUM_BOUNDS*LINE_W-1:0] clamp_bnd_i,
  input  logic [PTR_W-1:0]             clamp_ptr_i,
  input  logic [NUM_BOUNDS*LINE_W-1:0] pblk_bnd_i,
  input  logic [PTR_W-1:0]             pblk_ptr_i,
  input  logic [NUM_BOUNDS*LINE_W-1:0] hblk_bnd_i,
  input  logic [PTR_W-1:0]             hblk_ptr_i,
  output logic [SEL_W-1:0]             clamp_sel_o,
  output logic [SEL_W-1:0]             pblk_sel_o,
  output logic [SEL_W-1:0]             hblk_sel_o
);
  logic [LINE_W-1:0]            line_next;
  logic                         boundary;
  logic [NUM_BOUNDS*LINE_W-1:0] bnd_arr [NUM_LANES];
  logic [PTR_W-1:0]             ptr_arr [NUM_LANES];
  seq_sel_t                     sel_arr [NUM_LANES];

  assign bnd_arr[0] = clamp_bnd_i;
  assign bnd_arr[1] = pblk_bnd_i;
  assign bnd_arr[2] = hblk_bnd_i;
  assign ptr_arr[0] = clamp_ptr_i;
  assign ptr_arr[1] = pblk_ptr_i;
  assign ptr_arr[2] = hblk_ptr_i;

  lrs_line_counter #(.LINE_W(LINE_W)) u_counter (
    .clk           (clk),
    .rst_n         (rst_n),
    .field_start_i (field_start_i),
    .line_stb_i    (line_stb_i),
    .line_next_o   (line_next),
    .boundary_o    (boundary)
  );

  for (genvar s = 0; s < NUM_LANES; s++) begin : g_lane
    lrs_region_sel #(.LINE_W(LINE_W)) u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .boundary_i  (boundary),
      .line_next_i (line_next),
      .bnd_i       (bnd_arr[s]),
      .ptr_i       (ptr_arr[s]),
      .sel_o       (sel_arr[s])
    );
  end

  assign clamp_sel_o = sel_arr[0];
  assign pblk_sel_o  = sel_arr[1];
  assign hblk_sel_o  = sel_arr[2];

  // R11
  rst_sel_zero_chk: assert property (@(posedge clk)
    !rst_n |-> (clamp_sel_o == '0 && pblk_sel_o == '0 && hblk_sel_o == '0));
endmodule

// File: tb/line_region_seqsel_bench.sv
module line_region_seqsel_bench;
  localparam int LW = 12;
  localparam int NV = 10;
  localparam logic [LW-1:0] VL [NV] = '{12'd0, 12'd2, 12'd3, 12'd4, 12'd5,
                                         12'd9, 12'd10, 12'd19, 12'd20, 12'd25};
  // expected {clamp, pblk, hblk}
  localparam logic [5:0] VE [NV] = '{
    {2'd0, 2'd3, 2'd2}, {2'd0, 2'd3, 2'd2}, {2'd0, 2'd2, 2'd2}, {2'd0, 2'd2, 2'd2},
    {2'd1, 2'd2, 2'd2}, {2'd1, 2'd2, 2'd2}, {2'd2, 2'd2, 2'd2}, {2'd2, 2'd2, 2'd2},
    {2'd3, 2'd2, 2'd2}, {2'd3, 2'd2, 2'd2}};

  logic clk = 1'b0, rst_n = 1'b0, fs = 1'b0, ls = 1'b0;
  logic [3*LW-1:0] c_bnd, p_bnd, h_bnd;
  logic [7:0] c_ptr, p_ptr, h_ptr;
  logic [1:0] c_sel, p_sel, h_sel;
  int n_run = 0, n_fail = 0;
  int cur = 0;

  always #4 clk = ~clk;

  line_region_seqsel #(.LINE_W(LW)) u_line_region_seqsel (
    .clk(clk), .rst_n(rst_n), .field_start_i(fs), .line_stb_i(ls),
    .clamp_bnd_i(c_bnd), .clamp_ptr_i(c_ptr), .pblk_bnd_i(p_bnd), .pblk_ptr_i(p_ptr),
    .hblk_bnd_i(h_bnd), .hblk_ptr_i(h_ptr),
    .clamp_sel_o(c_sel), .pblk_sel_o(p_sel), .hblk_sel_o(h_sel));

  task automatic chk(input string req, input logic [5:0] exp);
    n_run++;
    if ({c_sel, p_sel, h_sel} !== exp) begin
      n_fail++;
      $display("FAIL %s: got c/p/h=%0d/%0d/%0d expected %0d/%0d/%0d", req,
               c_sel, p_sel, h_sel, exp[5:4], exp[3:2], exp[1:0]);
    end
  endtask

  task automatic field_pulse();
    @(negedge clk) fs = 1'b1;
    @(negedge clk) fs = 1'b0;
    cur = 0;
  endtask

  task automatic lines(input int n);
    if (n > 0) begin
      @(negedge clk) ls = 1'b1;
      repeat (n) @(negedge clk);
      ls = 1'b0;
      cur += n;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    c_bnd = {12'd20, 12'd10, 12'd5};  c_ptr = 8'hE4;
    p_bnd = {12'd30, 12'd2,  12'd3};  p_ptr = 8'h1B;
    h_bnd = {12'd9,  12'd7,  12'd0};  h_ptr = 8'hFE;
    repeat (3) @(negedge clk);
    chk("R11 reset", 6'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 after release", 6'd0);

    field_pulse();
    for (int i = 0; i < NV; i++) begin
      lines(int'(VL[i]) - cur);
      chk("R3 R4 R5 R6 R7 table", VE[i]);
    end

    // R8: pointer change without strobe has no effect
    c_ptr = 8'h1B;
    repeat (3) @(negedge clk);
    chk("R8 hold", {2'd3, 2'd2, 2'd2});
    lines(1);
    chk("R8 after strobe", {2'd0, 2'd2, 2'd2});

    // R1: mid-field restart
    field_pulse();
    chk("R1 restart", {2'd3, 2'd3, 2'd2});
    lines(5);

    // R9: field start wins over line strobe
    @(negedge clk) begin fs = 1'b1; ls = 1'b1; end
    @(negedge clk) begin fs = 1'b0; ls = 1'b0; end
    cur = 0;
    chk("R9 both strobes", {2'd3, 2'd3, 2'd2});
    lines(4);
    chk("R9 line 4", {2'd3, 2'd2, 2'd2});
    lines(1);
    chk("R2 line 5", {2'd2, 2'd2, 2'd2});

    // R10: saturation at line 4095
    c_bnd = {12'd4095, 12'd10, 12'd5}; c_ptr = 8'hE4;
    field_pulse();
    lines(4094);
    chk("R10 line 4094", {2'd2, 2'd2, 2'd2});
    lines(1);
    chk("R10 line 4095", {2'd3, 2'd2, 2'd2});
    lines(5);
    chk("R10 saturated", {2'd3, 2'd2, 2'd2});

    // R5: first boundary zero disables the clamp lane boundaries
    c_bnd = {12'd20, 12'd10, 12'd0};
    field_pulse();
    lines(15);
    chk("R5 zero first boundary", {2'd0, 2'd2, 2'd2});
    lines(10);
    chk("R5 past later boundaries", {2'd0, 2'd2, 2'd2});

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule